// File: doc/BRIEF.md
# Aliased System Control Register File

This block is the register front end for a four-channel measurement device. It receives whole 29-bit command words on a parallel interface: one word per clock, qualified by a valid strobe. It decodes each word and updates one device-wide system control register or one or more per-channel registers. From these it drives the device's static controls:
- channel enables and clamp enables;
- comparator power, comparator output enables and tri-state controls;
- the source select for the shared open-drain alarm;
- DUT-ground/guard pin mode, the sense-short switches and the guard amplifier.

Two groups of bits have one storage location but can be written through two paths: the clamp enables and the comparator output enables. A write through the system register or through a channel's own register changes the same bit. A readback through either register returns whatever was written last, by either path. A read command returns a registered word with a one-cycle valid pulse.

Command word layout:

| Bits | Field |
|------|-------|
| 28 | Read flag (1 = read) |
| 27:24 | Channel mask (bit 24 = channel 0) |
| 23:22 | Mode |
| 21:0 | Payload |

Top module: `aliased_sysctl_regs`

## Requirements
- R1: After a synchronous reset every control output is 0. This includes chanEn, clampEn, cmpOutEn, cmpDriveEn, cmpPowerOn, dutGndMode, senseShort, guardAmpEn, alarmPullLow and rdValid. A readback of the system register then returns all zeros.
- R2: A valid word with read flag 0, mask 0 and mode 0 writes the system register. The following fields are loaded from the payload:

  | Bits | Field |
  |------|-------|
  | 21:18 | Clamp enables (bit 18 = channel 0) |
  | 17:14 | Comparator output enables (bit 14 = channel 0) |
  | 13 | Comparator power |
  | 12 | DUT-ground mode (1) / guard-input mode (0) |
  | 11 | Guard alarm select |
  | 10 | Clamp alarm select |
  | 9 | Sense short |
  | 8 | Guard amplifier enable |

  The outputs change one clock after the word is accepted.
- R3: A valid word with read flag 0, mode 0 and a nonzero mask writes the register of every channel whose mask bit is set. Bit 21 loads chanEn, bit 20 loads clampEn and bit 19 loads cmpOutEn. Channels whose mask bit is clear keep their values.
- R4: The clamp enables and comparator output enables are shared between the system path and the channel path. When both paths write the same bit, including on consecutive clocks, the later write sets the value. Both readback paths then show that value.
- R5: cmpDriveEn[c] is 1 only when cmpPowerOn is 1 and cmpOutEn[c] is 1. Otherwise that comparator output stays high-impedance.
- R6: alarmPullLow is 1 when either of these holds:
  - the guard alarm select is 1 and any guardAlarm input is 1;
  - the clamp alarm select is 1 and any clampAlarm input is 1.

  Otherwise it is 0 (released). It follows the alarm inputs with no clock delay.
- R7: A valid word with read flag 1 makes rdValid high for exactly the next clock, with the readback on rdData in that same cycle.
  - A system register read returns the R2 layout in bits 21:8, with all other bits 0.
  - A channel read returns chanEn, clampEn and cmpOutEn of the lowest-numbered masked channel in bits 21, 20 and 19, with all other bits 0.
  - A read changes no control output.
- R8: A valid word whose mode is not 0 changes no control output. If that word is a read, it returns an all-zero word.
- R9: A word presented while cmdValid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command word strobe |
| cmdWord | input | 29 | Command word |
| guardAlarm | input | 4 | Per-channel guard alarm conditions |
| clampAlarm | input | 4 | Per-channel clamp alarm conditions |
| chanEn | output | 4 | Channel enables |
| clampEn | output | 4 | Clamp enables (shared storage) |
| cmpOutEn | output | 4 | Comparator output enable bits (shared storage) |
| cmpDriveEn | output | 4 | 1 = comparator output drives, 0 = high-impedance |
| cmpPowerOn | output | 1 | Comparator power |
| dutGndMode | output | 1 | 1 = DUT-ground pins, 0 = guard inputs |
| senseShort | output | 1 | Closes both sense-short switches |
| guardAmpEn | output | 1 | Guard amplifier enable |
| alarmPullLow | output | 1 | Open-drain alarm: 1 pulls the line low |
| rdValid | output | 1 | Readback valid pulse |
| rdData | output | 29 | Readback word |

## Verification
Every stored bit except the two alarm selects drives an output pin directly. A corrupted register therefore shows on the ports at the first negative edge after the write that should have set it. The alarm selects are seen only through alarmPullLow, and only once an alarm input is raised. Because storage is shared, a bit written through the wrong path, or a second copy of a bit, shows up in two places:
- the clamp or comparator enable outputs after a cross-path write;
- the readback word from the other register, one cycle after the read.

The readback scoreboard compares each returned word with the expected value in order. A dropped, extra or late rdValid pulse misaligns the queue at once.

// File: rtl/aliased_ctl_pkg.sv
package aliased_ctl_pkg;
  localparam int NUM_CH   = 4;
  localparam int WORD_W   = 29;
  localparam int MODE_W   = 2;
  localparam int CH_IDX_W = $clog2(NUM_CH);

  // command field positions
  localparam int RD_BIT   = 28;
  localparam int MASK_LO  = 24;
  localparam int MODE_LO  = 22;

  // payload slice handed to the datapath
  localparam int PAY_LO   = 8;
  localparam int PAY_HI   = 21;
  localparam int PAY_W    = PAY_HI - PAY_LO + 1;

  // system register fields, absolute word positions
  localparam int SYS_CLAMP_LO = 18;
  localparam int SYS_OE_LO    = 14;
  localparam int SYS_PWR      = 13;
  localparam int SYS_DUT      = 12;
  localparam int SYS_GALM     = 11;
  localparam int SYS_CALM     = 10;
  localparam int SYS_SENSE    = 9;
  localparam int SYS_GUARD    = 8;

  // channel register fields, absolute word positions
  localparam int CH_EN_BIT    = 21;
  localparam int CH_CLAMP_BIT = 20;
  localparam int CH_OE_BIT    = 19;

  typedef struct packed {
    logic                sysWr;
    logic                sysRd;
    logic [NUM_CH-1:0]   chWr;
    logic                chRd;
    logic [CH_IDX_W-1:0] chRdIdx;
    logic                nullRd;
  } strobe_t;
endpackage

// File: rtl/aliased_cmd_decode.sv
module aliased_cmd_decode
  import aliased_ctl_pkg::*;
(
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output strobe_t           stb
);
  logic [NUM_CH-1:0] chMask;
  logic [MODE_W-1:0] modeSel;
  logic              isRead;
  logic              regSpace;
  logic              sysHit;
  logic              chHit;
  logic [CH_IDX_W-1:0] lowIdx;

  assign chMask   = cmdWord[MASK_LO +: NUM_CH];
  assign modeSel  = cmdWord[MODE_LO +: MODE_W];
  assign isRead   = cmdWord[RD_BIT];
  assign regSpace = (modeSel == '0);
  assign sysHit   = regSpace && (chMask == '0);
  assign chHit    = regSpace && (chMask != '0);

  // lowest-numbered selected channel wins a channel readback
  always_comb begin
    lowIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (chMask[c]) lowIdx = CH_IDX_W'(c);
    end
  end

  always_comb begin
    stb.sysWr   = cmdValid && !isRead && sysHit;
    stb.sysRd   = cmdValid &&  isRead && sysHit;
    stb.chWr    = (cmdValid && !isRead && chHit) ? chMask : '0;
    stb.chRd    = cmdValid &&  isRead && chHit;
    stb.chRdIdx = lowIdx;
    stb.nullRd  = cmdValid &&  isRead && !regSpace;
  end
endmodule

// File: rtl/aliased_ctl_datapath.sv
module aliased_ctl_datapath
  import aliased_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [PAY_W-1:0]  payload,
  input  logic [NUM_CH-1:0] guardAlarm,
  input  logic [NUM_CH-1:0] clampAlarm,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] clampEn,
  output logic [NUM_CH-1:0] cmpOutEn,
  output logic [NUM_CH-1:0] cmpDriveEn,
  output logic              cmpPowerOn,
  output logic              dutGndMode,
  output logic              senseShort,
  output logic              guardAmpEn,
  output logic              alarmPullLow,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  localparam int P_CLAMP = SYS_CLAMP_LO - PAY_LO;
  localparam int P_OE    = SYS_OE_LO    - PAY_LO;
  localparam int P_PWR   = SYS_PWR      - PAY_LO;
  localparam int P_DUT   = SYS_DUT      - PAY_LO;
  localparam int P_GALM  = SYS_GALM     - PAY_LO;
  localparam int P_CALM  = SYS_CALM     - PAY_LO;
  localparam int P_SENSE = SYS_SENSE    - PAY_LO;
  localparam int P_GUARD = SYS_GUARD    - PAY_LO;
  localparam int P_CHEN  = CH_EN_BIT    - PAY_LO;
  localparam int P_CHCL  = CH_CLAMP_BIT - PAY_LO;
  localparam int P_CHOE  = CH_OE_BIT    - PAY_LO;

  logic guardAlmSel;
  logic clampAlmSel;

  // shared (aliased) per-channel storage: one bit, two write paths
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        chanEn[c]   <= 1'b0;
        clampEn[c]  <= 1'b0;
        cmpOutEn[c] <= 1'b0;
      end else if (stb.sysWr) begin
        clampEn[c]  <= payload[P_CLAMP + c];
        cmpOutEn[c] <= payload[P_OE + c];
      end else if (stb.chWr[c]) begin
        chanEn[c]   <= payload[P_CHEN];
        clampEn[c]  <= payload[P_CHCL];
        cmpOutEn[c] <= payload[P_CHOE];
      end
    end
    assign cmpDriveEn[c] = cmpPowerOn & cmpOutEn[c];
  end

  // device-wide fields
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpPowerOn  <= 1'b0;
      dutGndMode  <= 1'b0;
      guardAlmSel <= 1'b0;
      clampAlmSel <= 1'b0;
      senseShort  <= 1'b0;
      guardAmpEn  <= 1'b0;
    end else if (stb.sysWr) begin
      cmpPowerOn  <= payload[P_PWR];
      dutGndMode  <= payload[P_DUT];
      guardAlmSel <= payload[P_GALM];
      clampAlmSel <= payload[P_CALM];
      senseShort  <= payload[P_SENSE];
      guardAmpEn  <= payload[P_GUARD];
    end
  end

  assign alarmPullLow = (guardAlmSel && (|guardAlarm)) ||
                        (clampAlmSel && (|clampAlarm));

  // readback assembly
  logic [WORD_W-1:0] sysWord;
  logic [WORD_W-1:0] chWord;

  always_comb begin
    sysWord = '0;
    sysWord[SYS_CLAMP_LO +: NUM_CH] = clampEn;
    sysWord[SYS_OE_LO +: NUM_CH]    = cmpOutEn;
    sysWord[SYS_PWR]   = cmpPowerOn;
    sysWord[SYS_DUT]   = dutGndMode;
    sysWord[SYS_GALM]  = guardAlmSel;
    sysWord[SYS_CALM]  = clampAlmSel;
    sysWord[SYS_SENSE] = senseShort;
    sysWord[SYS_GUARD] = guardAmpEn;
  end

  always_comb begin
    chWord = '0;
    chWord[CH_EN_BIT]    = chanEn[stb.chRdIdx];
    chWord[CH_CLAMP_BIT] = clampEn[stb.chRdIdx];
    chWord[CH_OE_BIT]    = cmpOutEn[stb.chRdIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.sysRd || stb.chRd || stb.nullRd;
      if (stb.sysRd)       rdData <= sysWord;
      else if (stb.chRd)   rdData <= chWord;
      else if (stb.nullRd) rdData <= '0;
    end
  end
endmodule

// File: rtl/aliased_sysctl_regs.sv
module aliased_sysctl_regs
  import aliased_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [NUM_CH-1:0] guardAlarm,
  input  logic [NUM_CH-1:0] clampAlarm,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] clampEn,
  output logic [NUM_CH-1:0] cmpOutEn,
  output logic [NUM_CH-1:0] cmpDriveEn,
  output logic              cmpPowerOn,
  output logic              dutGndMode,
  output logic              senseShort,
  output logic              guardAmpEn,
  output logic              alarmPullLow,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  strobe_t stb;

  aliased_cmd_decode u_decode (
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .stb      (stb)
  );

  aliased_ctl_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .payload      (cmdWord[PAY_HI:PAY_LO]),
    .guardAlarm   (guardAlarm),
    .clampAlarm   (clampAlarm),
    .chanEn       (chanEn),
    .clampEn      (clampEn),
    .cmpOutEn     (cmpOutEn),
    .cmpDriveEn   (cmpDriveEn),
    .cmpPowerOn   (cmpPowerOn),
    .dutGndMode   (dutGndMode),
    .senseShort   (senseShort),
    .guardAmpEn   (guardAmpEn),
    .alarmPullLow (alarmPullLow),
    .rdValid      (rdValid),
    .rdData       (rdData)
  );
endmodule

// File: rtl/aliased_ctl_chk.sv
module aliased_ctl_chk
  import aliased_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic [WORD_W-1:0] cmdWord,
  input logic [NUM_CH-1:0] guardAlarm,
  input logic [NUM_CH-1:0] clampAlarm,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] clampEn,
  input logic [NUM_CH-1:0] cmpOutEn,
  input logic [NUM_CH-1:0] cmpDriveEn,
  input logic              cmpPowerOn,
  input logic              alarmPullLow,
  input logic              rdValid
);
  // R1: reset clears the stored enables
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (chanEn == '0 && clampEn == '0 && cmpOutEn == '0 && !cmpPowerOn && !rdValid));

  // R5: a comparator output never drives without comparator power
  a_r5_drive_needs_power: assert property (@(posedge clk) disable iff (rst)
    (|cmpDriveEn) |-> cmpPowerOn);

  // R6: the alarm line is never pulled without some alarm input
  a_r6_alarm_has_source: assert property (@(posedge clk) disable iff (rst)
    alarmPullLow |-> ((|guardAlarm) || (|clampAlarm)));

  // R7: every read command yields a valid pulse on the next cycle
  a_r7_read_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdWord[RD_BIT]) |=> rdValid);

  // R7: a valid pulse only follows a read command
  a_r7_valid_from_read: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(cmdValid && cmdWord[RD_BIT]));

  // R7: a read leaves the stored enables unchanged
  a_r7_read_no_change: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdWord[RD_BIT]) |=> ($stable(chanEn) && $stable(clampEn) && $stable(cmpOutEn)));

  // R8: a word outside register mode leaves the stored enables unchanged
  a_r8_mode_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdWord[MODE_LO +: 2] != 2'b00) |=>
      ($stable(chanEn) && $stable(clampEn) && $stable(cmpOutEn) && $stable(cmpPowerOn)));

  // R9: no strobe, no change
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> ($stable(chanEn) && $stable(clampEn) && $stable(cmpOutEn) && $stable(cmpPowerOn)));
endmodule

bind aliased_sysctl_regs aliased_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmdValid     (cmdValid),
  .cmdWord      (cmdWord),
  .guardAlarm   (guardAlarm),
  .clampAlarm   (clampAlarm),
  .chanEn       (chanEn),
  .clampEn      (clampEn),
  .cmpOutEn     (cmpOutEn),
  .cmpDriveEn   (cmpDriveEn),
  .cmpPowerOn   (cmpPowerOn),
  .alarmPullLow (alarmPullLow),
  .rdValid      (rdValid)
);

// File: tb/test_aliased_sysctl_regs.sv
module test_aliased_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [28:0] cmdWord = '0;
  logic [3:0]  guardAlarm = '0;
  logic [3:0]  clampAlarm = '0;
  logic [3:0]  chanEn, clampEn, cmpOutEn, cmpDriveEn;
  logic        cmpPowerOn, dutGndMode, senseShort, guardAmpEn, alarmPullLow;
  logic        rdValid;
  logic [28:0] rdData;

  aliased_sysctl_regs i_aliased_sysctl_regs (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .guardAlarm(guardAlarm), .clampAlarm(clampAlarm),
    .chanEn(chanEn), .clampEn(clampEn), .cmpOutEn(cmpOutEn), .cmpDriveEn(cmpDriveEn),
    .cmpPowerOn(cmpPowerOn), .dutGndMode(dutGndMode), .senseShort(senseShort),
    .guardAmpEn(guardAmpEn), .alarmPullLow(alarmPullLow),
    .rdValid(rdValid), .rdData(rdData)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // expected-state model built from the requirements
  logic [3:0] mChan = '0, mClamp = '0, mOe = '0;
  logic       mPow = 0, mDut = 0, mGSel = 0, mCSel = 0, mSense = 0, mGuard = 0;

  typedef struct { logic [28:0] word; string tag; } exp_t;
  exp_t expQ[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] mk(input logic rd, input logic [3:0] mask,
                                     input logic [1:0] mode, input logic [21:0] pay);
    return {rd, mask, mode, pay};
  endfunction

  function automatic logic [28:0] sysImage();
    return {7'b0, mClamp, mOe, mPow, mDut, mGSel, mCSel, mSense, mGuard, 8'b0};
  endfunction

  // driver: enters and leaves at a negative edge
  task automatic sendCmd(input logic [28:0] w, input string tag);
    exp_t e;
    cmdWord  = w;
    cmdValid = 1'b1;
    if (w[23:22] != 2'b00) begin
      if (w[28]) begin e.word = '0; e.tag = tag; expQ.push_back(e); end
    end else if (w[28]) begin
      e.tag = tag;
      if (w[27:24] == 4'b0) e.word = sysImage();
      else begin
        e.word = '0;
        for (int c = 3; c >= 0; c--)
          if (w[24 + c]) e.word = {7'b0, mChan[c], mClamp[c], mOe[c], 19'b0};
      end
      expQ.push_back(e);
    end else if (w[27:24] == 4'b0) begin
      mClamp = w[21:18]; mOe = w[17:14]; mPow = w[13]; mDut = w[12];
      mGSel = w[11]; mCSel = w[10]; mSense = w[9]; mGuard = w[8];
    end else begin
      for (int c = 0; c < 4; c++)
        if (w[24 + c]) begin mChan[c] = w[21]; mClamp[c] = w[20]; mOe[c] = w[19]; end
    end
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkState(input string tag);
    check({tag, " chanEn"},     chanEn,     mChan);
    check({tag, " clampEn"},    clampEn,    mClamp);
    check({tag, " cmpOutEn"},   cmpOutEn,   mOe);
    check({tag, " cmpDriveEn R5"}, cmpDriveEn, mOe & {4{mPow}});
    check({tag, " misc"}, {cmpPowerOn, dutGndMode, senseShort, guardAmpEn},
          {mPow, mDut, mSense, mGuard});
  endtask

  // monitor: pops the expected readback for every valid pulse
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      if (expQ.size() == 0) check("R7 unexpected rdValid", 1, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check({"R7 readback ", e.tag}, rdData, e.word);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkState("R1 reset");
    check("R1 rdValid", rdValid, 0);
    check("R1 alarm", alarmPullLow, 0);
    sendCmd(mk(1, 4'b0, 2'b00, '0), "R1 sys after reset");
    @(negedge clk);

    // R2 system write, power off: enables stored, nothing drives (R5)
    sendCmd(mk(0, 4'b0, 2'b00, {4'b1010, 4'b0110, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 8'h00}), "R2");
    checkState("R2 write");
    // R5 power on
    sendCmd(mk(0, 4'b0, 2'b00, {4'b1010, 4'b0110, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'h00}), "R5");
    checkState("R5 power");
    check("R5 drive", cmpDriveEn, 4'b0110);

    // R3 channel write ch0 only; R4 alias shows in sys readback
    sendCmd(mk(0, 4'b0001, 2'b00, {1'b1, 1'b1, 1'b1, 19'b0}), "R3");
    checkState("R3 ch0");
    check("R4 clamp via channel", clampEn, 4'b1011);
    sendCmd(mk(1, 4'b0, 2'b00, '0), "R4 sys sees ch write");
    sendCmd(mk(1, 4'b0001, 2'b00, '0), "R4 ch0 read");
    // R3 multi-channel mask, channel readback uses lowest set bit
    sendCmd(mk(0, 4'b1100, 2'b00, {1'b1, 1'b0, 1'b1, 19'b0}), "R3 multi");
    checkState("R3 multi");
    sendCmd(mk(1, 4'b1100, 2'b00, '0), "R7 ch lowest");
    // R4 back-to-back: sys write then channel write on the next clock
    sendCmd(mk(0, 4'b0, 2'b00, {4'b0000, 4'b1111, 1'b1, 1'b0, 2'b11, 2'b00, 8'h00}), "R4 a");
    sendCmd(mk(0, 4'b0100, 2'b00, {1'b0, 1'b1, 1'b0, 19'b0}), "R4 b");
    checkState("R4 back2back");
    check("R4 clampEn", clampEn, 4'b0100);
    check("R4 cmpOutEn", cmpOutEn, 4'b1011);
    sendCmd(mk(1, 4'b0100, 2'b00, '0), "R4 ch2 read");
    sendCmd(mk(1, 4'b0, 2'b00, '0), "R4 sys read");
    checkState("R7 read no change");

    // R6 alarm select combinations (both selects now 1)
    guardAlarm = 4'b0010; #1;
    check("R6 guard", alarmPullLow, 1);
    guardAlarm = 4'b0; clampAlarm = 4'b1000; #1;
    check("R6 clamp", alarmPullLow, 1);
    @(negedge clk);
    sendCmd(mk(0, 4'b0, 2'b00, {4'b0000, 4'b1111, 1'b1, 1'b0, 2'b10, 2'b00, 8'h00}), "R6 gsel");
    #1 check("R6 clamp masked", alarmPullLow, 0);
    clampAlarm = 4'b0; guardAlarm = 4'b0001; #1;
    check("R6 guard only", alarmPullLow, 1);
    guardAlarm = 4'b0; #1;
    check("R6 none", alarmPullLow, 0);
    @(negedge clk);

    // R8 other modes: write ignored, read returns zero
    sendCmd(mk(0, 4'b0000, 2'b01, 22'h3FFFFF), "R8 w");
    checkState("R8 mode1 write");
    sendCmd(mk(0, 4'b1111, 2'b11, 22'h3FFFFF), "R8 w2");
    checkState("R8 mode3 write");
    sendCmd(mk(1, 4'b0001, 2'b10, '0), "R8 read zero");
    // R9 word present but not valid
    cmdWord = mk(0, 4'b0, 2'b00, 22'h3FFFFF);
    @(negedge clk); @(negedge clk);
    checkState("R9 idle");
    @(negedge clk);
    check("R7 queue drained", expQ.size(), 0);

    // R1 reset restores defaults
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    mChan = 0; mClamp = 0; mOe = 0; mPow = 0; mDut = 0; mGSel = 0; mCSel = 0; mSense = 0; mGuard = 0;
    checkState("R1 re-reset");
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule